// File: doc/BRIEF.md
# Circuit-Switched Memory Gateway Controller

This controller sits next to a DRAM access point and serves memory requests that reach it over a packet network. The data itself does not travel through that network. It moves over an end-to-end circuit that the controller reserves for one access at a time. Contending accesses are not reordered or arbitrated here. Contention is settled by whichever request wins the circuit, and each access is one long burst whose length the controller knows before it starts.

On a read, the controller sets up two routes: from the command modulators to the DIMM, and from the DIMM toward the network. It then offers a path-setup message to the requester and waits for that requester's acknowledge. A programmable timeout bounds the wait. Only after the acknowledge does it emit one combined row/column command word. It then waits the row-to-column delay and times the column latency plus the data burst. At the end it releases the circuit on its own.

On a write, the request itself serves as the path setup. The controller first routes the modulators to the DIMM and issues the command word. After the row-to-column delay it routes the network to the DIMM and acknowledges the writer. The writer then streams its data and signals the end of the circuit itself.

Top module: `mgw_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle, and that is its state after reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: From the cycle after a read is taken until the circuit is released, `sw_cmd_en` and `sw_rd_en` are high and `sw_wr_en` is low. `path_peer` carries the request's source ID.
- R3: During a read, `setup_valid` stays high from the cycle after acceptance until the cycle in which `ack_in` is sampled high. No command word is issued before that acknowledge.
- R4: The command word is valid for exactly one cycle. For a read, that cycle follows the acknowledge cycle. Its layout is {write flag at the MSB, burst length in BL_W bits, address}. The address is {bank, row, column}, with the column in the low COL_W bits.
- R5: If no acknowledge arrives, a read with timeout value N holds `setup_valid` for N+1 cycles. In the following cycle the controller is idle with all switch enables low, and `err` is high for that one cycle only. No command word is issued. An acknowledge in the last waiting cycle still wins.
- R6: For a read, the first `data_en` cycle comes T_RCD+T_CL+1 cycles after the command cycle. `data_en` then stays high for exactly burst×BEAT_CYC consecutive cycles, and the controller is idle in the next cycle. A burst of zero gives no `data_en` cycle.
- R7: A write issues its command word in the first cycle after acceptance. During that cycle only `sw_cmd_en` is high among the switch enables, and `setup_valid` never rises.
- R8: On a write, `ack_out` is high for one cycle, T_RCD+1 cycles after the command cycle. `sw_wr_en` rises in that same cycle, and `path_peer` carries the source ID.
- R9: On a write, `data_en` is high from the cycle after `ack_out` until the cycle in which `teardown_in` is sampled high, and the controller is idle in the next cycle. `teardown_in` has no effect at any other time.
- R10: While a circuit is held, `req_ready` stays low, and a request held on `req_valid` is not taken.
- R11: Whenever the controller is idle, `sw_cmd_en`, `sw_rd_en`, `sw_wr_en` and `data_en` are low. This also holds after a reset that arrives during a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | Bank, row and column address |
| req_burst | input | BL_W | Burst length in beats |
| req_src | input | SRC_W | Requester ID |
| ack_timeout | input | TO_W | Acknowledge wait limit in cycles |
| sw_cmd_en | output | 1 | Route modulators to DIMM |
| sw_rd_en | output | 1 | Route DIMM to network |
| sw_wr_en | output | 1 | Route network to DIMM |
| setup_valid | output | 1 | Path-setup message to the reader |
| ack_in | input | 1 | Path acknowledge from the reader |
| ack_out | output | 1 | Path acknowledge to the writer |
| teardown_in | input | 1 | Writer ends its circuit |
| path_peer | output | SRC_W | Destination of setup or acknowledge |
| cmd_valid | output | 1 | Command word valid |
| cmd_word | output | 1+BL_W+BANK_W+ROW_W+COL_W | Combined row/column command |
| data_en | output | 1 | Data phase active |
| err | output | 1 | Acknowledge timeout pulse |

## Verification
A corrupt state register shows up at once as a wrong switch-enable pattern or as `req_ready` at the wrong time. The reason is that every port is decoded from the state in the same cycle. A wrong phase count does not appear until later: it shows when the first `data_en` cycle lands early or late, or when the burst comes out one beat long or short. That error becomes visible between T_RCD and T_RCD+T_CL+burst×BEAT_CYC cycles after the command word. A timeout counter that is off by one shows as one extra or one missing `setup_valid` cycle, and `err` fires in the wrong cycle.

// File: rtl/mgw_pkg.sv
package mgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_PATH,
      ST_CMD,
      ST_RCD,
      ST_RD_DATA,
      ST_WR_ACK,
      ST_WR_STREAM
   } mgw_state_e;
endpackage

// File: rtl/mgw_countdown.sv
module mgw_countdown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);
   generate
      if (W < 1) begin : g_bad_w
         $error("mgw_countdown: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/mgw_cmd_pack.sv
module mgw_cmd_pack #(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10,
   parameter int BL_W   = 8
) (
   input  logic                          wr,
   input  logic [BL_W-1:0]               burst,
   input  logic [BANK_W+ROW_W+COL_W-1:0] addr,
   output logic [BL_W+BANK_W+ROW_W+COL_W:0] word
);
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;

   logic [BANK_W-1:0] bank;
   logic [ROW_W-1:0]  row;
   logic [COL_W-1:0]  col;

   assign col  = addr[COL_W-1:0];
   assign row  = addr[COL_W +: ROW_W];
   assign bank = addr[ADDR_W-1 -: BANK_W];
   assign word = {wr, burst, bank, row, col};
endmodule

// File: rtl/mgw_ctrl.sv
module mgw_ctrl
   import mgw_pkg::*;
#(
   parameter int BANK_W   = 3,
   parameter int ROW_W    = 14,
   parameter int COL_W    = 10,
   parameter int BL_W     = 8,
   parameter int SRC_W    = 6,
   parameter int TO_W     = 8,
   parameter int T_RCD    = 10,
   parameter int T_CL     = 10,
   parameter int BEAT_CYC = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   output logic                             req_ready,
   input  logic                             req_write,
   input  logic [BANK_W+ROW_W+COL_W-1:0]    req_addr,
   input  logic [BL_W-1:0]                  req_burst,
   input  logic [SRC_W-1:0]                 req_src,
   input  logic [TO_W-1:0]                  ack_timeout,
   output logic                             sw_cmd_en,
   output logic                             sw_rd_en,
   output logic                             sw_wr_en,
   output logic                             setup_valid,
   input  logic                             ack_in,
   output logic                             ack_out,
   input  logic                             teardown_in,
   output logic [SRC_W-1:0]                 path_peer,
   output logic                             cmd_valid,
   output logic [BL_W+BANK_W+ROW_W+COL_W:0] cmd_word,
   output logic                             data_en,
   output logic                             err
);
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int CMD_W  = 1 + BL_W + ADDR_W;
   localparam int PH_MAX = ((2 ** BL_W) - 1) * BEAT_CYC + T_CL + T_RCD;
   localparam int PH_W   = $clog2(PH_MAX + 1);

   generate
      if (T_RCD < 1) begin : g_bad_rcd
         $error("mgw_ctrl: T_RCD must be at least 1");
      end
      if (T_CL < 1) begin : g_bad_cl
         $error("mgw_ctrl: T_CL must be at least 1");
      end
      if (BEAT_CYC < 1) begin : g_bad_beat
         $error("mgw_ctrl: BEAT_CYC must be at least 1");
      end
      if (BANK_W < 1 || ROW_W < 1 || COL_W < 1 || BL_W < 1 || SRC_W < 1 || TO_W < 1) begin : g_bad_w
         $error("mgw_ctrl: all field widths must be at least 1");
      end
   endgenerate

   mgw_state_e        state, state_nx;
   logic              lat_wr;
   logic [BL_W-1:0]   lat_burst;
   logic [ADDR_W-1:0] lat_addr;
   logic [SRC_W-1:0]  lat_src;
   logic              err_q;
   logic              accept;

   logic [PH_W-1:0]   ph_cnt, ph_val, beats;
   logic              ph_load;
   logic [TO_W-1:0]   to_cnt;

   assign accept = req_valid && (state == ST_IDLE);
   assign beats  = PH_W'(lat_burst) * PH_W'(BEAT_CYC);

   // phase timer: row-to-column wait, then column latency plus burst
   always_comb begin
      ph_load = 1'b0;
      ph_val  = '0;
      if (state == ST_CMD) begin
         ph_load = 1'b1;
         ph_val  = PH_W'(T_RCD - 1);
      end else if (state == ST_RCD && ph_cnt == '0 && !lat_wr) begin
         ph_load = 1'b1;
         ph_val  = beats + PH_W'(T_CL - 1);
      end
   end

   mgw_countdown #(.W(PH_W)) i_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .cnt      (ph_cnt)
   );

   mgw_countdown #(.W(TO_W)) i_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (ack_timeout),
      .cnt      (to_cnt)
   );

   mgw_cmd_pack #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BL_W(BL_W)) i_pack (
      .wr    (lat_wr),
      .burst (lat_burst),
      .addr  (lat_addr),
      .word  (cmd_word)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:      if (accept) state_nx = req_write ? ST_CMD : ST_RD_PATH;
         ST_RD_PATH:   if (ack_in) state_nx = ST_CMD;
                       else if (to_cnt == '0) state_nx = ST_IDLE;
         ST_CMD:       state_nx = ST_RCD;
         ST_RCD:       if (ph_cnt == '0) state_nx = lat_wr ? ST_WR_ACK : ST_RD_DATA;
         ST_RD_DATA:   if (ph_cnt == '0) state_nx = ST_IDLE;
         ST_WR_ACK:    state_nx = ST_WR_STREAM;
         ST_WR_STREAM: if (teardown_in) state_nx = ST_IDLE;
         default:      state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lat_wr    <= 1'b0;
         lat_burst <= '0;
         lat_addr  <= '0;
         lat_src   <= '0;
         err_q     <= 1'b0;
      end else begin
         state <= state_nx;
         err_q <= (state == ST_RD_PATH) && !ack_in && (to_cnt == '0);
         if (accept) begin
            lat_wr    <= req_write;
            lat_burst <= req_burst;
            lat_addr  <= req_addr;
            lat_src   <= req_src;
         end
      end
   end

   assign req_ready   = (state == ST_IDLE);
   assign sw_cmd_en   = (state != ST_IDLE);
   assign sw_rd_en    = !lat_wr && (state inside {ST_RD_PATH, ST_CMD, ST_RCD, ST_RD_DATA});
   assign sw_wr_en    = (state inside {ST_WR_ACK, ST_WR_STREAM});
   assign setup_valid = (state == ST_RD_PATH);
   assign ack_out     = (state == ST_WR_ACK);
   assign cmd_valid   = (state == ST_CMD);
   assign data_en     = ((state == ST_RD_DATA) && (ph_cnt < beats)) || (state == ST_WR_STREAM);
   assign path_peer   = lat_src;
   assign err         = err_q;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(sw_cmd_en || sw_rd_en || sw_wr_en || data_en)); // R11
   AST_RD_NO_WR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rd_en |-> (sw_cmd_en && !sw_wr_en)); // R2
   AST_NO_CMD_WO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_word[CMD_W-1]) |-> $past(ack_in)); // R3
   AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R4
   AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (req_ready && !sw_cmd_en && !cmd_valid)); // R5
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R5
   AST_WR_ACK_ROUTES: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out |-> (sw_wr_en && sw_cmd_en && !sw_rd_en && !setup_valid)); // R8
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_cmd_en && !$past(req_ready)) |-> !req_ready); // R10
endmodule

// File: tb/test_mgw_ctrl.sv
`timescale 1ns/1ps
module test_mgw_ctrl;
   localparam int BANK_W = 3, ROW_W = 14, COL_W = 10, BL_W = 8, SRC_W = 6, TO_W = 8;
   localparam int T_RCD = 10, T_CL = 10, BEAT = 4;
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int CMD_W  = 1 + BL_W + ADDR_W;

   typedef struct packed {
      logic              wr;
      logic [BL_W-1:0]   burst;
      logic [ADDR_W-1:0] addr;
      logic [SRC_W-1:0]  src;
      logic [7:0]        ack_dly;   // 8'hFF = never acknowledge
      logic [TO_W-1:0]   tmo;
      logic [7:0]        td;        // write data cycles before teardown
      logic              noise;     // hold req_valid and teardown_in during a read
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'd4,  27'h3ABCDEF, 6'd9,  8'd3,   8'd20, 8'd0, 1'b0},
      '{1'b0, 8'd1,  27'h0000001, 6'd1,  8'd0,   8'd0,  8'd0, 1'b0},
      '{1'b0, 8'd2,  27'h1234567, 6'd33, 8'hFF,  8'd5,  8'd0, 1'b0},
      '{1'b0, 8'd2,  27'h7FFFFFF, 6'd63, 8'd7,   8'd7,  8'd0, 1'b0},
      '{1'b0, 8'd2,  27'h0F0F0F0, 6'd12, 8'd8,   8'd7,  8'd0, 1'b0},
      '{1'b1, 8'd16, 27'h5555555, 6'd20, 8'd0,   8'd0,  8'd5, 1'b0},
      '{1'b1, 8'd1,  27'h2AAAAAA, 6'd2,  8'd0,   8'd0,  8'd1, 1'b0},
      '{1'b0, 8'd3,  27'h0C0FFEE, 6'd40, 8'd2,   8'd9,  8'd0, 1'b1},
      '{1'b0, 8'd0,  27'h4000000, 6'd7,  8'd2,   8'd9,  8'd0, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, ack_in = 1'b0, teardown_in = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [BL_W-1:0]   req_burst = '0;
   logic [SRC_W-1:0]  req_src = '0;
   logic [TO_W-1:0]   ack_timeout = '0;
   logic req_ready, sw_cmd_en, sw_rd_en, sw_wr_en, setup_valid, ack_out, cmd_valid, data_en, err;
   logic [SRC_W-1:0] path_peer;
   logic [CMD_W-1:0] cmd_word;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   mgw_ctrl i_mgw_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_burst(req_burst), .req_src(req_src),
      .ack_timeout(ack_timeout), .sw_cmd_en(sw_cmd_en), .sw_rd_en(sw_rd_en), .sw_wr_en(sw_wr_en),
      .setup_valid(setup_valid), .ack_in(ack_in), .ack_out(ack_out), .teardown_in(teardown_in),
      .path_peer(path_peer), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .data_en(data_en), .err(err)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle_outputs(input string tag);
      chk({tag, " ready"}, req_ready, 1);
      chk({tag, " switches and data off"}, {sw_cmd_en, sw_rd_en, sw_wr_en, data_en, cmd_valid}, 0);
   endtask

   task automatic run(input vec_t v);
      int cyc = 1, cmd_c = 0, ack_c = 0, dfirst = 0, dcnt = 0, setup_n = 0;
      int sw_bad = 0, peer_bad = 0, end_c;
      logic [CMD_W-1:0] word = '0;
      logic exp_err;
      longint exp_word;
      @(negedge clk);
      chk("R1 ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_burst = v.burst;
      req_src = v.src; ack_timeout = v.tmo;
      @(negedge clk);
      if (!v.noise) req_valid = 1'b0;
      teardown_in = v.noise;
      while (cyc < 3000) begin
         if (req_ready) break;
         if (setup_valid) begin
            setup_n++;
            if (path_peer != v.src) peer_bad++;
         end
         if (cmd_valid) begin cmd_c = cyc; word = cmd_word; end
         if (ack_out) begin
            ack_c = cyc;
            if (path_peer != v.src) peer_bad++;
         end
         if (data_en) begin
            if (dcnt == 0) dfirst = cyc;
            dcnt++;
         end
         if (!sw_cmd_en || sw_rd_en != !v.wr || sw_wr_en != (v.wr && ack_c != 0)) sw_bad++;
         ack_in = !v.wr && setup_valid && v.ack_dly != 8'hFF && setup_n == int'(v.ack_dly) + 1;
         teardown_in = v.noise || (v.wr && data_en && dcnt == int'(v.td));
         @(negedge clk);
         cyc++;
      end
      end_c = cyc;
      ack_in = 1'b0; teardown_in = 1'b0; req_valid = 1'b0;
      exp_word = longint'({v.wr, v.burst, v.addr});
      if (!v.wr) begin
         exp_err = (v.ack_dly > v.tmo);
         chk("R5 err flag at release", err, exp_err);
         chk("R2 read routes held", sw_bad, 0);
         chk("R2 setup peer id", peer_bad, 0);
         if (exp_err) begin
            chk("R5 setup cycles on timeout", setup_n, v.tmo + 1);
            chk("R5 no command on timeout", cmd_c, 0);
            chk("R5 idle cycle after timeout", end_c, v.tmo + 2);
         end else begin
            chk("R3 setup held until ack", setup_n, v.ack_dly + 1);
            chk("R4 command after ack", cmd_c, v.ack_dly + 2);
            chk("R4 command word layout", longint'(word), exp_word);
            chk("R6 read data beats", dcnt, v.burst * BEAT);
            if (v.burst != 0) chk("R6 first data cycle", dfirst, cmd_c + T_RCD + T_CL + 1);
            chk("R6 read release cycle", end_c, cmd_c + T_RCD + T_CL + 1 + v.burst * BEAT);
            if (v.noise) chk("R9 teardown ignored during read", dcnt, v.burst * BEAT);
         end
      end else begin
         chk("R5 no err on write", err, 0);
         chk("R7 no setup on write", setup_n, 0);
         chk("R7 write command first cycle", cmd_c, 1);
         chk("R7 write routes", sw_bad, 0);
         chk("R4 write command word layout", longint'(word), exp_word);
         chk("R8 write ack cycle", ack_c, T_RCD + 2);
         chk("R8 ack peer id", peer_bad, 0);
         chk("R9 write stream start", dfirst, ack_c + 1);
         chk("R9 write data cycles", dcnt, v.td);
         chk("R9 write release cycle", end_c, ack_c + 1 + v.td);
      end
      idle_outputs("R11 after transaction");
      if (v.noise) begin
         @(negedge clk);
         chk("R10 held request not taken", req_ready, 1);
         chk("R10 no circuit after held request", sw_cmd_en, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      idle_outputs("R1 reset state");
      chk("R1 err low after reset", err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_outputs("R11 idle after reset release");

      for (int k = 0; k < NV; k++) run(VEC[k]);

      // reset arriving while a read waits for its acknowledge
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_burst = 8'd2; ack_timeout = 8'd50;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 setup while waiting", setup_valid, 1);
      chk("R10 busy not ready", req_ready, 0);
      rst_n = 1'b0;
      @(negedge clk);
      idle_outputs("R11 reset during read");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      idle_outputs("R11 idle after mid reset");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule